// File: doc/BRIEF.md
# Prioritised Bus Grant Arbiter

This block is the central arbiter of a shared bus. It chooses which requester becomes the next bus master. Devices raise one of four interrupt-priority request lines, for levels 4 to 7, or a separate DMA request. The arbiter answers with exactly one grant line, which is asserted high. The chosen device confirms that it has been selected by pulling the shared selection-acknowledge line low. The arbiter then withdraws the grant at once. It waits until the device has released the acknowledge and has taken the bus by asserting bus-busy. After that it is free to pick the next master.

No grant waits for the bus to become idle. The next master is chosen and acknowledged while the current master still holds bus-busy low and is transferring data. This hides the arbitration time behind the transfer.

A DMA request outranks every interrupt level. An interrupt level is served only when it lies strictly above the processor's current priority level. The acknowledge limit is an input, so the wait can be changed at run time. It bounds two waits:
- how long an offered grant waits for an acknowledge;
- how long a selected device may take to become master.

When either wait runs out, the arbiter returns to idle and arbitrates again.

Top module: `bus_grant_arbiter`

## Requirements
- R1: When reset is sampled high, all five grant outputs are low on the next cycle, and the arbiter is idle.
- R2: A DMA request (req_dma_n low) is granted on grant_dma ahead of any interrupt request, for every value of cpu_pri.
- R3: Interrupt request bit i of req_lvl_n stands for level 4+i. It can win only when 4+i is strictly greater than the 3-bit value on cpu_pri. A masked request produces no grant.
- R4: Among the eligible interrupt requests, only the highest level is granted, on grant_lvl bit i for level 4+i.
- R5: At most one of the five grant outputs is high in any cycle.
- R6: A grant appears on the cycle after the winning request is sampled. It goes low on the cycle after sel_ack_n is sampled low.
- R7: While a grant waits for an acknowledge, it stays on the same line even if the requests or cpu_pri change.
- R8: If no acknowledge is sampled while a grant is up, the grant stays high for max(ack_limit,1) cycles and is then withdrawn. Arbitration restarts, so the grant can rise again one cycle later.
- R9: No new grant is issued while sel_ack_n is sampled low.
- R10: After an acknowledge, the next grant can be issued as soon as sel_ack_n is sampled high together with busy_n low. The arbiter never waits for busy_n to return high, so the next grant overlaps the running transfer.
- R11: If the selected device keeps the acknowledge low, or never asserts busy, the arbiter returns to idle after max(ack_limit,1) cycles. It can grant on the cycle after that, once sel_ack_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_lvl_n | input | 4 | Interrupt requests, active low, bit i is level 4+i |
| req_dma_n | input | 1 | DMA request, active low |
| sel_ack_n | input | 1 | Selection acknowledge from the chosen device, active low |
| busy_n | input | 1 | Bus busy, active low |
| cpu_pri | input | 3 | Current processor priority level |
| ack_limit | input | TMO_W (8) | Cycle limit for the acknowledge and takeover waits (0 acts as 1) |
| grant_lvl | output | 4 | Interrupt grants, active high, bit i is level 4+i |
| grant_dma | output | 1 | DMA grant, active high |

## Verification
The checks on the internal counter and the grant-hold checks assume that ack_limit changes only while the arbiter is idle. The bench therefore changes ack_limit only after a settling run has brought the arbiter back to idle. The checks that look back one cycle assume reset is held for several clock edges, and the bench holds it for three. Requests, acknowledge and busy may otherwise change freely. The random phase drives them independently, including acknowledges that are unsolicited or held for a long time. A cycle-level model in the bench predicts every grant vector, including the corner cases of that random stimulus.

// File: rtl/bga_pkg.sv
package bga_pkg;

    localparam int NUM_LVL  = 4;   // interrupt request levels served
    localparam int LVL_BASE = 4;   // priority number of the lowest level
    localparam int PRI_W    = 3;   // width of the processor priority input

    typedef enum logic [1:0] {
        ST_IDLE,      // free to pick the next master
        ST_OFFER,     // a grant is up, waiting for acknowledge
        ST_HANDOFF    // acknowledged, waiting for takeover of the bus
    } arb_state_e;

    typedef struct packed {
        logic               dma;
        logic [NUM_LVL-1:0] lvl;
    } grant_t;

    function automatic logic any_grant(grant_t g);
        return g.dma | (|g.lvl);
    endfunction

    function automatic logic level_eligible(int idx, logic [PRI_W-1:0] cur);
        return (LVL_BASE + idx) > int'(cur);
    endfunction

endpackage

// File: rtl/bga_pick.sv
module bga_pick
    import bga_pkg::*;
(
    input  logic [NUM_LVL-1:0] irq,
    input  logic               dma,
    input  logic [PRI_W-1:0]   cur_pri,
    output grant_t             pick
);

    logic [NUM_LVL-1:0] elig;

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_elig
        assign elig[i] = irq[i] && level_eligible(i, cur_pri);
    end

    // DMA first; otherwise the last eligible level in ascending order wins.
    always_comb begin
        pick = '0;
        if (dma) begin
            pick.dma = 1'b1;
        end else begin
            for (int k = 0; k < NUM_LVL; k++) begin
                if (elig[k]) begin
                    pick.lvl    = '0;
                    pick.lvl[k] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bga_timer.sv
module bga_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [TMO_W-1:0] lim,
    output logic             expire
);

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
    assign expire  = cnt_nxt >= {1'b0, lim};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && lim != '0) |-> (cnt_q < lim));

    // R11
    no_count_past_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        expire |-> !en);

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
    import bga_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] req_lvl_n,
    input  logic               req_dma_n,
    input  logic               sel_ack_n,
    input  logic               busy_n,
    input  logic [PRI_W-1:0]   cpu_pri,
    input  logic [TMO_W-1:0]   ack_limit,
    output logic [NUM_LVL-1:0] grant_lvl,
    output logic               grant_dma
);

    arb_state_e         st_q, st_d;
    grant_t             gr_q, gr_d;
    grant_t             winner;
    logic [NUM_LVL-1:0] irq_act;
    logic               dma_act;
    logic               ack, busy;
    logic               tmr_clr, tmr_en, tmr_expire;

    assign irq_act = ~req_lvl_n;
    assign dma_act = ~req_dma_n;
    assign ack     = ~sel_ack_n;
    assign busy    = ~busy_n;

    bga_pick u_pick (
        .irq     (irq_act),
        .dma     (dma_act),
        .cur_pri (cpu_pri),
        .pick    (winner)
    );

    bga_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .en     (tmr_en),
        .lim    (ack_limit),
        .expire (tmr_expire)
    );

    always_comb begin
        st_d    = st_q;
        gr_d    = gr_q;
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (!ack && any_grant(winner)) begin
                    st_d = ST_OFFER;
                    gr_d = winner;
                end
            end
            ST_OFFER: begin
                if (ack) begin
                    st_d    = ST_HANDOFF;
                    gr_d    = '0;
                    tmr_clr = 1'b1;
                end else if (tmr_expire) begin
                    st_d = ST_IDLE;
                    gr_d = '0;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            ST_HANDOFF: begin
                if (!ack && busy) begin
                    st_d = ST_IDLE;
                end else if (tmr_expire) begin
                    st_d = ST_IDLE;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            default: begin
                st_d = ST_IDLE;
                gr_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            gr_q <= '0;
        end else begin
            st_q <= st_d;
            gr_q <= gr_d;
        end
    end

    assign grant_lvl = gr_q.lvl;
    assign grant_dma = gr_q.dma;

    logic [NUM_LVL:0] gvec;
    assign gvec = {grant_dma, grant_lvl};

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gvec));

    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (gvec != '0 && !sel_ack_n) |=> (gvec == '0));

    // R2
    dma_first_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_lvl != '0 && $past(gvec) == '0) |-> $past(req_dma_n));

    // R9
    no_grant_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (gvec != '0 && $past(gvec) == '0) |-> $past(sel_ack_n));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gvec != '0 && $past(gvec) != '0) |-> (gvec == $past(gvec)));

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl_chk
        // R3
        lvl_above_chk: assert property (@(posedge clk) disable iff (rst)
            (grant_lvl[i] && !$past(grant_lvl[i]))
                |-> (!$past(req_lvl_n[i]) && ((LVL_BASE + i) > int'($past(cpu_pri)))));
    end

endmodule

// File: tb/bus_grant_arbiter_tb_top.sv
`timescale 1ns/100ps
module bus_grant_arbiter_tb_top;

    localparam int  TMO_W    = 8;
    localparam real HALF_PER = 2.5;
    localparam int  WATCHDOG = 200000;

    logic             clk = 1'b0;
    logic             rst;
    logic [3:0]       req_lvl_n;
    logic             req_dma_n;
    logic             sel_ack_n;
    logic             busy_n;
    logic [2:0]       cpu_pri;
    logic [TMO_W-1:0] ack_limit;
    logic [3:0]       grant_lvl;
    logic             grant_dma;

    always #(HALF_PER) clk = ~clk;

    bus_grant_arbiter #(.TMO_W(TMO_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_lvl_n (req_lvl_n),
        .req_dma_n (req_dma_n),
        .sel_ack_n (sel_ack_n),
        .busy_n    (busy_n),
        .cpu_pri   (cpu_pri),
        .ack_limit (ack_limit),
        .grant_lvl (grant_lvl),
        .grant_dma (grant_dma)
    );

    typedef struct {
        logic [4:0] g;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    // reference model state: 0 idle, 1 offer, 2 handoff
    int         m_st  = 0;
    int         m_cnt = 0;
    logic [4:0] m_g   = '0;

    function automatic logic [4:0] ref_pick();
        if (!req_dma_n) return 5'b10000;
        for (int l = 7; l >= 4; l--) begin
            if (!req_lvl_n[l-4] && l > int'(cpu_pri)) return 5'(1 << (l - 4));
        end
        return 5'b0;
    endfunction

    task automatic model_update();
        int         lim;
        logic [4:0] w;
        lim = int'(ack_limit);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_g = '0;
        end else begin
            case (m_st)
                0: if (sel_ack_n) begin
                       w = ref_pick();
                       if (w != 0) begin m_g = w; m_st = 1; m_cnt = 0; end
                   end
                1: if (!sel_ack_n) begin m_g = '0; m_st = 2; m_cnt = 0; end
                   else if (m_cnt + 1 >= lim) begin m_g = '0; m_st = 0; end
                   else m_cnt++;
                default: if (sel_ack_n && !busy_n) m_st = 0;
                   else if (m_cnt + 1 >= lim) m_st = 0;
                   else m_cnt++;
            endcase
        end
    endtask

    // driver side: advance one cycle and queue the predicted grants
    task automatic tick(string tag);
        exp_t e;
        @(posedge clk);
        model_update();
        e.g   = m_g;
        e.tag = tag;
        q.push_back(e);
        #1;
    endtask

    // monitor side: compare away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if ({grant_dma, grant_lvl} !== e.g) begin
                n_fails++;
                $display("FAIL %s: grants got %b expected %b", e.tag,
                         {grant_dma, grant_lvl}, e.g);
            end
        end
    end

    task automatic settle(int n);
        req_lvl_n = 4'hF; req_dma_n = 1'b1; sel_ack_n = 1'b1; busy_n = 1'b0;
        for (int k = 0; k < n; k++) tick("R1 settle");
        busy_n = 1'b1;
        tick("R1 settle");
    endtask

    initial begin
        #(2.0 * HALF_PER * WATCHDOG);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_lvl_n = 4'hF; req_dma_n = 1'b1; sel_ack_n = 1'b1;
        busy_n = 1'b1; cpu_pri = 3'd0; ack_limit = 8'd4;
        tick("R1 reset"); tick("R1 reset"); tick("R1 reset");
        rst = 1'b0;
        tick("R1 idle");

        // R2: DMA beats all levels even at top processor priority
        cpu_pri = 3'd7; req_lvl_n = 4'h0; req_dma_n = 1'b0;
        tick("R2 dma grant");
        tick("R7 hold");
        sel_ack_n = 1'b0;
        tick("R6 ack drop");
        req_dma_n = 1'b1;
        tick("R9 ack low");
        sel_ack_n = 1'b1;
        tick("R10 busy not yet asserted");
        busy_n = 1'b0;
        tick("R10 takeover");
        settle(3);

        // R3: masking against processor priority
        cpu_pri = 3'd5; req_lvl_n = 4'b1100;
        tick("R3 masked"); tick("R3 masked");
        req_lvl_n = 4'b1000;
        tick("R3 level 6 above 5");
        sel_ack_n = 1'b0;
        tick("R6 ack drop");
        settle(5);

        // R4: highest eligible wins
        cpu_pri = 3'd0; req_lvl_n = 4'b0101;
        tick("R4 level 7 over 5");
        req_lvl_n = 4'b1101; cpu_pri = 3'd7;
        tick("R7 hold across change");
        sel_ack_n = 1'b0;
        tick("R6 ack drop");
        settle(5);

        // R10: grant while the bus is still busy
        busy_n = 1'b0; cpu_pri = 3'd3; req_lvl_n = 4'b1110;
        tick("R10 grant overlaps busy");
        sel_ack_n = 1'b0;
        tick("R6 ack drop");
        sel_ack_n = 1'b1; req_lvl_n = 4'b1101;
        tick("R10 handoff done");
        tick("R10 next grant while busy");
        settle(6);

        // R8: acknowledge timeout and re-arbitration
        ack_limit = 8'd3; req_dma_n = 1'b0;
        for (int k = 0; k < 7; k++) tick("R8 timeout limit 3");
        settle(5);
        ack_limit = 8'd0; req_dma_n = 1'b0;
        for (int k = 0; k < 4; k++) tick("R8 timeout limit 0");
        settle(3);
        ack_limit = 8'd4;
        tick("R1 idle");

        // R11: handoff that never completes
        req_dma_n = 1'b0;
        tick("R2 dma grant");
        sel_ack_n = 1'b0;
        tick("R6 ack drop");
        for (int k = 0; k < 5; k++) tick("R11 ack held");
        sel_ack_n = 1'b1;
        tick("R9 grant after ack release");
        settle(6);

        // R5: random mixes of requests, priority, acknowledge, busy
        ack_limit = 8'd5;
        for (int k = 0; k < 400; k++) begin
            req_lvl_n = 4'($urandom);
            req_dma_n = ($urandom % 4) != 0;
            cpu_pri   = 3'($urandom);
            sel_ack_n = ($urandom % 3) != 0;
            busy_n    = 1'($urandom);
            tick("R5 random");
        end
        settle(8);

        @(negedge clk);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule